// File: doc/BRIEF.md
# PRBS Test Pattern Monitor

This block checks a received serial test stream against a selected test pattern. It accepts one bit per handshake, locks onto the pattern by loading its own pattern register from the arriving bits, and then predicts each following bit. While locked, every mismatch is counted as a bit error. Too many errors in a short span cause a loss of sync, and the block goes back to hunting. Four patterns can be chosen: a 15-stage and a 20-stage pseudorandom sequence, an alternating 1/0 pattern, and an all-ones pattern.

The stream interface is valid/ready. The monitor never applies back-pressure: `in_ready` is high in every cycle after reset, and a bit is taken on each cycle in which `in_valid` is high. A qualifier, `in_payload`, marks the bits that belong to the test payload. An accepted bit with the qualifier low is thrown away. Frame alignment is handled upstream, and its loss-of-frame state enters on `lof_in`.

Software can poll a saturating error count with a clear strobe, the sync state, and three sticky event flags. It can also enable any of those flags onto a single interrupt line.

Top module: `prbs_mon`

## Requirements
- R1: `in_ready` is 1 whenever the block is out of reset. Only bits accepted with `in_valid`=1 and `in_payload`=1 advance the checker. Any other cycle leaves the sync state, the predicted sequence and `err_count` unchanged.
- R2: `pat_sel` encoding: 0 selects b[n]=b[n-15] xor b[n-14], 1 selects b[n]=b[n-20] xor b[n-17], 2 selects alternating bits, 3 selects all ones.
- R3: While hunting, received bits are shifted into the local register. Sync is declared after N consecutive correct predictions, where N is 15 for pattern 0, 20 for pattern 1 and FIX_SYNC (16) for patterns 2 and 3. `in_sync` rises in the cycle after the completing bit. A clean pseudorandom stream locks between bit N and bit 2N. A clean fixed pattern whose first bit is 1 locks at bit 16.
- R4: For patterns 0 and 1, a prediction made from an all-zero history never counts as a match, so an all-zero stream never gains sync.
- R5: While locked, the local sequence runs free. Each mismatching payload bit raises `err_count` by one in the next cycle, so one flipped bit gives exactly one error. Bits received while hunting are never counted.
- R6: `err_count` is CNT_W bits wide (16 by default) and holds at its all-ones value once it gets there.
- R7: A cycle with `err_clr`=1 leaves `err_count` at 0 in the next cycle, or at 1 if that same cycle carried an errored bit.
- R8: Windows of WIN_LEN (64) locked payload bits are counted from the first bit after sync is gained. The error that takes a window's count to LOS_THRESH (4) drops `in_sync` in the next cycle. Three errors in each window keep sync.
- R9: A change of `pat_sel` returns the block to hunting in the next cycle and does not set the sync-loss flag. A bit accepted in that same cycle is discarded.
- R10: `irq_status` bit 0 is sync gained, bit 1 is sync lost by the error rule (R8), and bit 2 is a rising edge of `lof_in`. Each bit is set in the cycle after its event and stays set until a 1 is written to the same bit of `status_clr`. A new event has priority over a clear in the same cycle.
- R11: `irq` is 1 exactly while some `irq_status` bit is set whose `irq_mask` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A stream bit is offered |
| in_ready | output | 1 | Monitor takes the bit (high out of reset) |
| in_bit | input | 1 | Stream bit value |
| in_payload | input | 1 | Bit belongs to the test payload |
| pat_sel | input | 2 | Pattern select (R2) |
| lof_in | input | 1 | Loss-of-frame state from the framer |
| err_clr | input | 1 | Clear strobe for the error count |
| err_count | output | CNT_W | Saturating bit-error count |
| in_sync | output | 1 | Pattern lock state |
| irq_mask | input | 3 | Per-flag interrupt enable |
| status_clr | input | 3 | Write-one-to-clear for the sticky flags |
| irq_status | output | 3 | Sticky event flags (R10) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `rst_n` is held for at least one clock edge, and that `err_clr` and `status_clr` are single-cycle strobes driven in step with the clock. They do not assume any pacing of `in_valid`. The stream bits, qualifier and pattern may change in any cycle. The stimulus changes all inputs only on the falling clock edge. It changes `pat_sel` only in cycles that carry no bit, and it places injected errors at chosen offsets inside the 64-bit windows, so every loss of sync is one that was intended.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;

  typedef enum logic [1:0] {
    PAT_PRBS15 = 2'd0,
    PAT_PRBS20 = 2'd1,
    PAT_ALT    = 2'd2,
    PAT_ONES   = 2'd3
  } pat_e;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } sync_st_e;

  // history register spans the longest generator
  localparam int HIST_W   = 20;
  localparam int LEN15    = 15;
  localparam int LEN20    = 20;
  localparam int TAP15_A  = 14;
  localparam int TAP15_B  = 13;
  localparam int TAP20_A  = 19;
  localparam int TAP20_B  = 16;

  // sticky flag positions
  localparam int FLG_GAIN = 0;
  localparam int FLG_LOSS = 1;
  localparam int FLG_LOF  = 2;
  localparam int NFLAG    = 3;

endpackage

// File: rtl/prbs_mon_predict.sv
module prbs_mon_predict
  import prbs_mon_pkg::*;
(
  input  pat_e              pat,
  input  logic [HIST_W-1:0] hist,
  output logic              pred,
  output logic              live
);

  // hist[0] is the newest bit, hist[k] the bit k+1 places back
  always_comb begin
    pred = 1'b1;
    live = 1'b1;
    case (pat)
      PAT_PRBS15: begin
        pred = hist[TAP15_A] ^ hist[TAP15_B];
        live = |hist[LEN15-1:0];
      end
      PAT_PRBS20: begin
        pred = hist[TAP20_A] ^ hist[TAP20_B];
        live = |hist[LEN20-1:0];
      end
      PAT_ALT: begin
        pred = ~hist[0];
        live = 1'b1;
      end
      default: begin
        pred = 1'b1;
        live = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/prbs_mon_sync.sv
module prbs_mon_sync
  import prbs_mon_pkg::*;
#(
  parameter int FIX_SYNC   = 16,
  parameter int WIN_LEN    = 64,
  parameter int LOS_THRESH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              rx_bit,
  input  pat_e              pat,
  input  logic              restart,
  input  logic              pred,
  input  logic              live,
  output logic [HIST_W-1:0] hist,
  output logic              locked,
  output logic              bit_err,
  output logic              gain,
  output logic              loss
);

  localparam int MAXN = (HIST_W > FIX_SYNC) ? HIST_W : FIX_SYNC;
  localparam int MW   = $clog2(MAXN + 1);
  localparam int WW   = $clog2(WIN_LEN);
  localparam int EW   = $clog2(LOS_THRESH + 1);

  sync_st_e        st;
  logic [MW-1:0]   mcnt;
  logic [MW-1:0]   need;
  logic [WW-1:0]   wcnt;
  logic [EW-1:0]   werr;
  logic [EW-1:0]   werr_sum;
  logic            match;
  logic            hunt_hit;
  logic            wrap;

  always_comb begin
    case (pat)
      PAT_PRBS15: need = MW'(LEN15);
      PAT_PRBS20: need = MW'(LEN20);
      default:    need = MW'(FIX_SYNC);
    endcase
  end

  assign match    = (rx_bit == pred);
  assign hunt_hit = fire && (st == ST_HUNT) && match && live;
  assign gain     = hunt_hit && ((mcnt + MW'(1)) == need);
  assign bit_err  = fire && (st == ST_LOCK) && !match;
  assign werr_sum = werr + EW'(bit_err);
  assign loss     = bit_err && (werr_sum >= EW'(LOS_THRESH));
  assign wrap     = (wcnt == WW'(WIN_LEN - 1));
  assign locked   = (st == ST_LOCK);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      st   <= ST_HUNT;
      hist <= '0;
      mcnt <= '0;
      wcnt <= '0;
      werr <= '0;
    end else if (fire) begin
      if (st == ST_HUNT) begin
        hist <= {hist[HIST_W-2:0], rx_bit};
        if (gain) begin
          st   <= ST_LOCK;
          mcnt <= '0;
          wcnt <= '0;
          werr <= '0;
        end else if (hunt_hit) begin
          mcnt <= mcnt + MW'(1);
        end else begin
          mcnt <= '0;
        end
      end else if (loss) begin
        st   <= ST_HUNT;
        hist <= '0;
        mcnt <= '0;
        wcnt <= '0;
        werr <= '0;
      end else begin
        hist <= {hist[HIST_W-2:0], pred};
        if (wrap) begin
          wcnt <= '0;
          werr <= '0;
        end else begin
          wcnt <= wcnt + WW'(1);
          werr <= werr_sum;
        end
      end
    end
  end

endmodule

// File: rtl/prbs_mon_errcnt.sv
module prbs_mon_errcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= {{(CNT_W-1){1'b0}}, inc};
    end else if (inc && (cnt != TOP)) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/prbs_mon_irq.sv
module prbs_mon_irq #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set,
  input  logic [NSRC-1:0] clr,
  input  logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] sticky,
  output logic            irq
);

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) sticky[i] <= 1'b0;
      else        sticky[i] <= set[i] | (sticky[i] & ~clr[i]);
    end
  end

  assign irq = |(sticky & mask);

endmodule

// File: rtl/prbs_mon.sv
module prbs_mon
  import prbs_mon_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FIX_SYNC   = 16,
  parameter int WIN_LEN    = 64,
  parameter int LOS_THRESH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  input  logic             in_payload,
  input  logic [1:0]       pat_sel,
  input  logic             lof_in,
  input  logic             err_clr,
  output logic [CNT_W-1:0] err_count,
  output logic             in_sync,
  input  logic [2:0]       irq_mask,
  input  logic [2:0]       status_clr,
  output logic [2:0]       irq_status,
  output logic             irq
);

  logic              rdy_q;
  pat_e              pat_q;
  logic              pat_change;
  logic              fire;
  logic              lof_q;
  logic              pred;
  logic              live;
  logic [HIST_W-1:0] hist;
  logic              bit_err;
  logic              gain_p;
  logic              loss_p;
  logic [NFLAG-1:0]  ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      pat_q <= PAT_PRBS15;
      lof_q <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      pat_q <= pat_e'(pat_sel);
      lof_q <= lof_in;
    end
  end

  assign in_ready   = rdy_q;
  assign pat_change = (pat_sel != pat_q);
  assign fire       = in_valid && rdy_q && in_payload && !pat_change;

  prbs_mon_predict u_pred (
    .pat  (pat_q),
    .hist (hist),
    .pred (pred),
    .live (live)
  );

  prbs_mon_sync #(
    .FIX_SYNC   (FIX_SYNC),
    .WIN_LEN    (WIN_LEN),
    .LOS_THRESH (LOS_THRESH)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .rx_bit  (in_bit),
    .pat     (pat_q),
    .restart (pat_change),
    .pred    (pred),
    .live    (live),
    .hist    (hist),
    .locked  (in_sync),
    .bit_err (bit_err),
    .gain    (gain_p),
    .loss    (loss_p)
  );

  prbs_mon_errcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (bit_err),
    .clr   (err_clr),
    .cnt   (err_count)
  );

  always_comb begin
    ev           = '0;
    ev[FLG_GAIN] = gain_p;
    ev[FLG_LOSS] = loss_p;
    ev[FLG_LOF]  = lof_in && !lof_q;
  end

  prbs_mon_irq #(.NSRC(NFLAG)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (ev),
    .clr    (status_clr),
    .mask   (irq_mask),
    .sticky (irq_status),
    .irq    (irq)
  );

endmodule

// File: rtl/prbs_mon_chk.sv
module prbs_mon_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_payload,
  input logic             err_clr,
  input logic [CNT_W-1:0] err_count,
  input logic             in_sync,
  input logic [2:0]       status_clr,
  input logic [2:0]       irq_status
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  p_ignore_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_payload) && !err_clr) |=> $stable(err_count));

  p_hunt_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sync && !err_clr) |=> $stable(err_count));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr |=> ((err_count == $past(err_count)) ||
                  (err_count == $past(err_count) + CNT_W'(1))));

  p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_count == TOP) && !err_clr) |=> (err_count == TOP));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> (err_count <= CNT_W'(1)));

  p_gain_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> irq_status[0]);

  p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_status) |=> ((($past(irq_status) & ~$past(status_clr)) & ~irq_status) == 3'b000));

endmodule

bind prbs_mon prbs_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_payload (in_payload),
  .err_clr    (err_clr),
  .err_count  (err_count),
  .in_sync    (in_sync),
  .status_clr (status_clr),
  .irq_status (irq_status)
);

// File: tb/prbs_mon_bench.sv
module prbs_mon_bench;

  localparam int CW  = 6;
  localparam int WIN = 64;
  localparam int TOPV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          in_bit = 1'b0;
  logic          in_payload = 1'b0;
  logic [1:0]    pat_sel = 2'd0;
  logic          lof_in = 1'b0;
  logic          err_clr = 1'b0;
  logic [CW-1:0] err_count;
  logic          in_sync;
  logic [2:0]    irq_mask = 3'b000;
  logic [2:0]    status_clr = 3'b000;
  logic [2:0]    irq_status;
  logic          irq;

  always #2 clk = ~clk;

  prbs_mon #(.CNT_W(CW)) u_prbs_mon (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_payload(in_payload), .pat_sel(pat_sel),
    .lof_in(lof_in), .err_clr(err_clr), .err_count(err_count),
    .in_sync(in_sync), .irq_mask(irq_mask), .status_clr(status_clr),
    .irq_status(irq_status), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  int wpos = 0;
  int exp_err = 0;
  int cur_mode = 0;
  logic [19:0] g15 = 20'h5A5A5;
  logic [19:0] g20 = 20'hC3A71;
  logic alt_last = 1'b0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic b, input logic pay, input logic vld, input logic clr);
    logic was;
    was = in_sync;
    in_bit = b; in_payload = pay; in_valid = vld; err_clr = clr;
    @(negedge clk);
    in_valid = 1'b0; in_payload = 1'b0; err_clr = 1'b0;
    if (was && vld && pay) wpos = (wpos + 1) % WIN;
    if (!was && in_sync) wpos = 0;
  endtask

  task automatic idle(input logic [2:0] sclr, input logic eclr);
    status_clr = sclr; err_clr = eclr;
    @(negedge clk);
    status_clr = 3'b000; err_clr = 1'b0;
  endtask

  task automatic gen(output logic b);
    case (cur_mode)
      0: begin b = g15[14] ^ g15[13]; g15 = {g15[18:0], b}; end
      1: begin b = g20[19] ^ g20[16]; g20 = {g20[18:0], b}; end
      2: begin b = ~alt_last; alt_last = b; end
      default: b = 1'b1;
    endcase
  endtask

  task automatic clean(input int n);
    logic b;
    for (int i = 0; i < n; i++) begin
      gen(b);
      push(b, 1'b1, 1'b1, 1'b0);
    end
  endtask

  task automatic err_bit();
    logic b;
    gen(b);
    push(~b, 1'b1, 1'b1, 1'b0);
    if (exp_err < TOPV) exp_err++;
  endtask

  task automatic align();
    while (wpos != 0) clean(1);
  endtask

  task automatic hunt(input int maxbits, output int k);
    k = -1;
    for (int i = 1; i <= maxbits; i++) begin
      clean(1);
      if (in_sync) begin k = i; break; end
    end
  endtask

  task automatic t_reset();
    chk("R1", "ready after reset", in_ready, 1);
    chk("R3", "sync after reset", in_sync, 0);
    chk("R5", "count after reset", err_count, 0);
    chk("R10", "flags after reset", irq_status, 0);
    chk("R11", "irq after reset", irq, 0);
  endtask

  task automatic t_sync15();
    int k;
    irq_mask = 3'b001;
    cur_mode = 0;
    hunt(40, k);
    chk("R3", $sformatf("prbs15 lock bit %0d in [15,30]", k), (k >= 15 && k <= 30) ? 1 : 0, 1);
    chk("R10", "gain flag", irq_status[0], 1);
    chk("R11", "irq with gain enabled", irq, 1);
    clean(100);
    chk("R5", "clean stream no errors", err_count, 0);
  endtask

  task automatic t_single_err();
    align(); clean(10);
    err_bit();
    chk("R5", "one flipped bit", err_count, exp_err);
    chk("R5", "still locked", in_sync, 1);
    clean(80);
    err_bit();
    clean(70);
    chk("R5", "second flip, clean after", err_count, exp_err);
  endtask

  task automatic t_ignore();
    int e;
    e = err_count;
    for (int i = 0; i < 20; i++) push(1'($urandom), 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) push(1'($urandom), 1'b1, 1'b0, 1'b0);
    chk("R1", "sync kept over ignored bits", in_sync, 1);
    chk("R1", "count kept over ignored bits", err_count, e);
    chk("R1", "ready during stream", in_ready, 1);
    clean(40);
    chk("R1", "sequence not advanced by ignored bits", err_count, e);
  endtask

  task automatic t_clear();
    logic b;
    idle(3'b000, 1'b1);
    exp_err = 0;
    chk("R7", "clear without error", err_count, 0);
    gen(b);
    push(~b, 1'b1, 1'b1, 1'b1);
    exp_err = 1;
    chk("R7", "clear with error same cycle", err_count, 1);
    clean(20);
  endtask

  task automatic t_window();
    align();
    clean(5); err_bit(); clean(9); err_bit(); clean(9); err_bit();
    align();
    chk("R8", "three errors keep sync", in_sync, 1);
    chk("R8", "three errors counted", err_count, exp_err);
    clean(5); err_bit(); clean(9); err_bit(); clean(9); err_bit();
    chk("R8", "still locked before fourth", in_sync, 1);
    clean(9); err_bit();
    chk("R8", "fourth error drops sync", in_sync, 0);
    chk("R10", "loss flag", irq_status[1], 1);
    chk("R5", "count includes fourth", err_count, exp_err);
  endtask

  task automatic t_resync();
    int k;
    idle(3'b111, 1'b0);
    chk("R10", "write-one clears flags", irq_status, 0);
    chk("R11", "irq low after clear", irq, 0);
    hunt(40, k);
    chk("R3", $sformatf("relock bit %0d in [15,30]", k), (k >= 15 && k <= 30) ? 1 : 0, 1);
    chk("R10", "only gain flag after relock", irq_status, 3'b001);
  endtask

  task automatic t_sat();
    idle(3'b000, 1'b1);
    exp_err = 0;
    align();
    for (int w = 0; w < 25; w++) begin
      clean(5); err_bit(); clean(9); err_bit(); clean(9); err_bit();
      align();
    end
    chk("R6", "count saturates", err_count, TOPV);
    chk("R8", "sync kept at 3 per window", in_sync, 1);
  endtask

  task automatic t_pat_change();
    int k;
    pat_sel = 2'd1;
    idle(3'b000, 1'b0);
    chk("R9", "pattern change drops sync", in_sync, 0);
    chk("R9", "no loss flag on pattern change", irq_status[1], 0);
    cur_mode = 1;
    hunt(50, k);
    chk("R2", $sformatf("prbs20 lock bit %0d in [20,40]", k), (k >= 20 && k <= 40) ? 1 : 0, 1);
  endtask

  task automatic t_zero();
    pat_sel = 2'd0;
    idle(3'b000, 1'b0);
    for (int i = 0; i < 100; i++) push(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R4", "all-zero stream never locks", in_sync, 0);
  endtask

  task automatic t_fixed();
    int k;
    pat_sel = 2'd2;
    idle(3'b000, 1'b1);
    exp_err = 0;
    cur_mode = 2; alt_last = 1'b0;
    hunt(30, k);
    chk("R3", "alternating lock at bit 16", k, 16);
    err_bit();
    chk("R2", "alternating error counted", err_count, 1);
    clean(10);
    chk("R2", "alternating clean after error", err_count, 1);
    pat_sel = 2'd3;
    idle(3'b000, 1'b1);
    cur_mode = 3;
    hunt(30, k);
    chk("R3", "all-ones lock at bit 16", k, 16);
    push(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R2", "zero in all-ones is an error", err_count, 1);
  endtask

  task automatic t_lof();
    idle(3'b111, 1'b0);
    irq_mask = 3'b000;
    lof_in = 1'b1;
    idle(3'b000, 1'b0);
    chk("R10", "frame loss flag", irq_status[2], 1);
    chk("R11", "masked flag keeps irq low", irq, 0);
    irq_mask = 3'b100;
    #1;
    chk("R11", "enabled flag raises irq", irq, 1);
    idle(3'b100, 1'b0);
    chk("R10", "level lof does not re-set", irq_status[2], 0);
    chk("R11", "irq low after clear", irq, 0);
    lof_in = 1'b0;
    idle(3'b000, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sync15();
    t_single_err();
    t_ignore();
    t_clear();
    t_window();
    t_resync();
    t_sat();
    t_pat_change();
    t_zero();
    t_fixed();
    t_lof();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog run did not end actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule